// File: doc/BRIEF.md
# Audio Converter Frame and Bit Clock Generator

This block sits beside a two-channel audio converter and decides how its serial port is clocked. Two strap pins choose one of three master speeds (single, double or quad) or slave operation. A ratio strap says whether the master clock runs at the normal or the doubled multiple of the sample rate for that speed. In master operation the block divides the master clock down to a frame clock at the sample rate (Fs) and a bit clock at 64 × Fs. In slave operation it leaves both clock outputs low, because the frame and bit clocks come from elsewhere.

The straps are sampled once, while the part leaves reset. Reset release is resynchronised on falling master-clock edges, so several converters whose resets are released together start counting on the same master-clock edge. Their frames then stay aligned. When the master clock is only 64 × Fs, one bit per master-clock period is needed. The bit clock is then the inverted master clock passed through a registered enable, not the output of a divider flop.

Top module: `acg_clkgen`

## Requirements
- R1: Mode pins 00, 01 and 10 give master operation at single, double and quad speed. slave_o is 0 and speed_o reports 2'b00, 2'b01 and 2'b10 respectively.
- R2: Mode pins 11 give slave operation. slave_o is 1, speed_o reads 2'b11, and lrck_o and bclk_o stay low.
- R3: In master operation the frame clock period is 256, 128 or 64 master-clock cycles for single, double or quad speed. When hi_ratio_i was 1 at reset release, the period doubles to 512, 256 or 128.
- R4: In master operation the bit clock has exactly 64 rising edges in each frame-clock period.
- R5: At quad speed with hi_ratio_i = 0, bclk_o equals the inverted master clock while running.
- R6: The frame clock changes only where the bit clock falls.
- R7: While rst_ni is low, lrck_o and bclk_o are low, slave_o is 1 and speed_o is 2'b11.
- R8: Release of rst_ni passes through two falling master-clock edges before the counter runs. Take release just after a rising edge, and call that rising edge number 0. With a frame of N master-clock cycles, lrck_o is low through rising edge N/2 and is first seen high after rising edge N/2+1. Each frame therefore begins with its low half.
- R9: Mode pins and hi_ratio_i are captured only during reset release. Changes to them while running leave speed_o, slave_o and the clock periods unchanged until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode straps: 00 single, 01 double, 10 quad, 11 slave |
| hi_ratio_i | input | 1 | 1 = master clock at the doubled ratio, engaging the divide-by-2 pre-stage |
| lrck_o | output | 1 | Frame clock at Fs (low half first) |
| bclk_o | output | 1 | Bit clock at 64 × Fs |
| slave_o | output | 1 | 1 = slave operation (or in reset) |
| speed_o | output | 2 | Latched speed code, 2'b11 in slave or reset |

## Verification
Mode and slave outputs are due one rising edge after reset release and are checked once counting has begun. The first frame-clock rise is due exactly N/2+1 rising edges after a release placed 2 ns past a rising edge. The bench counts rising edges and samples 2 ns after each one. Period, bit count and edge alignment are measured by sampling 2 ns after every master-clock transition. Each change of a divided output is therefore seen within the same half period it occurs in, and each pass-through bit-clock phase is seen in its own half.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_EXT    = 2'b11
  } speed_e;
endpackage

// File: rtl/acg_rst_sync.sv
// Reset release resynchronised on falling master-clock edges.
module acg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/acg_mode_latch.sv
// Captures the straps while the reset synchroniser is still releasing.
module acg_mode_latch
  import acg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic [1:0] mode_i,
  input  logic       hi_ratio_i,
  output speed_e     speed_o,
  output logic       slave_o,
  output logic       hi_ratio_o
);
  speed_e speed_q, speed_d;
  logic   slave_q, slave_d;
  logic   ratio_q, ratio_d;

  always_comb begin
    speed_d = speed_q;
    slave_d = slave_q;
    ratio_d = ratio_q;
    if (capture_i) begin
      speed_d = speed_e'(mode_i);
      slave_d = (mode_i == 2'b11);
      ratio_d = hi_ratio_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= SPD_EXT;
      slave_q <= 1'b1;
      ratio_q <= 1'b0;
    end else begin
      speed_q <= speed_d;
      slave_q <= slave_d;
      ratio_q <= ratio_d;
    end
  end

  assign speed_o    = speed_q;
  assign slave_o    = slave_q;
  assign hi_ratio_o = ratio_q;
endmodule

// File: rtl/acg_divider.sv
// Free-running counter; frame and bit clocks taken from the bit positions
// that the speed and the pre-divide select.
module acg_divider
  import acg_pkg::*;
#(
  parameter int BASE_LOG  = 8,
  parameter int BIT_SHIFT = 6,
  parameter int CNT_W     = BASE_LOG + 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cnt_en_i,
  input  speed_e speed_i,
  input  logic   hi_ratio_i,
  output logic   frame_o,
  output logic   bclk_o,
  output logic   pass_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             frame_q, frame_d;
  logic             bclk_q, bclk_d;
  logic             pass_q, pass_d;
  int               tlog;
  int               fidx;
  int               bidx;

  always_comb begin
    tlog = BASE_LOG - int'(speed_i) + int'(hi_ratio_i);
    fidx = tlog - 1;
    if (fidx < 0) fidx = 0;
    if (fidx > CNT_W - 1) fidx = CNT_W - 1;
    bidx = tlog - 1 - BIT_SHIFT;
    if (bidx < 0) bidx = 0;
    if (bidx > CNT_W - 1) bidx = CNT_W - 1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en_i) cnt_d = cnt_q + CNT_W'(1);
    frame_d = cnt_en_i & cnt_d[fidx];
    bclk_d  = cnt_en_i & (tlog > BIT_SHIFT) & cnt_d[bidx];
    pass_d  = cnt_en_i & (tlog == BIT_SHIFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
      bclk_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
      bclk_q  <= bclk_d;
      pass_q  <= pass_d;
    end
  end

  assign frame_o = frame_q;
  assign bclk_o  = bclk_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/acg_clkgen.sv
module acg_clkgen
  import acg_pkg::*;
#(
  parameter int SINGLE_DIV     = 256,
  parameter int BITS_PER_FRAME = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       hi_ratio_i,
  output logic       lrck_o,
  output logic       bclk_o,
  output logic       slave_o,
  output logic [1:0] speed_o
);
  localparam int BASE_LOG  = $clog2(SINGLE_DIV);
  localparam int BIT_SHIFT = $clog2(BITS_PER_FRAME);
  localparam int CNT_W     = BASE_LOG + 1;

  logic   run;
  speed_e speed_q;
  logic   slave_q;
  logic   ratio_q;
  logic   cnt_en;
  logic   frame;
  logic   bclk_div;
  logic   pass_en;

  acg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (mclk_i),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  acg_mode_latch u_mode (
    .clk_i      (mclk_i),
    .rst_ni     (rst_ni),
    .capture_i  (!run),
    .mode_i     (mode_i),
    .hi_ratio_i (hi_ratio_i),
    .speed_o    (speed_q),
    .slave_o    (slave_q),
    .hi_ratio_o (ratio_q)
  );

  assign cnt_en = run & !slave_q;

  acg_divider #(
    .BASE_LOG  (BASE_LOG),
    .BIT_SHIFT (BIT_SHIFT),
    .CNT_W     (CNT_W)
  ) u_div (
    .clk_i      (mclk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en),
    .speed_i    (speed_q),
    .hi_ratio_i (ratio_q),
    .frame_o    (frame),
    .bclk_o     (bclk_div),
    .pass_o     (pass_en)
  );

  assign lrck_o  = frame;
  assign bclk_o  = pass_en ? ~mclk_i : bclk_div;
  assign slave_o = slave_q;
  assign speed_o = speed_q;
endmodule

// File: rtl/acg_clkgen_chk.sv
module acg_clkgen_chk (
  input logic       mclk_i,
  input logic       rst_ni,
  input logic       lrck_o,
  input logic       bclk_o,
  input logic       slave_o,
  input logic [1:0] speed_o,
  input logic       ratio_q
);
  // R2
  slave_quiet_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    slave_o |-> (!lrck_o && !bclk_o));

  // R1
  speed_code_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !slave_o |-> (speed_o != 2'b11));

  // R9
  mode_hold_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    lrck_o |=> ($stable(speed_o) && $stable(slave_o)));

  // R6
  frame_edge_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (!slave_o && !(speed_o == 2'b10 && !ratio_q) && !$stable(lrck_o))
      |-> $fell(bclk_o));
endmodule

bind acg_clkgen acg_clkgen_chk u_chk (
  .mclk_i  (mclk_i),
  .rst_ni  (rst_ni),
  .lrck_o  (lrck_o),
  .bclk_o  (bclk_o),
  .slave_o (slave_o),
  .speed_o (speed_o),
  .ratio_q (ratio_q)
);

// File: tb/acg_clkgen_tb_top.sv
module acg_clkgen_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       hi;
  logic       lrck, bclk, slave;
  logic [1:0] speed;

  int n_chk  = 0;
  int n_fail = 0;

  localparam int NV = 8;
  localparam int V_PINS [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
  localparam int V_HI   [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_SPD  [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
  localparam int V_SLV  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int V_PER  [NV] = '{256, 512, 128, 256, 64, 128, 0, 0};

  acg_clkgen dut_i (
    .mclk_i     (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .hi_ratio_i (hi),
    .lrck_o     (lrck),
    .bclk_o     (bclk),
    .slave_o    (slave),
    .speed_o    (speed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reset with given straps; checks reset state and first frame rise.
  task automatic do_reset(input int pins, input int h, input int per);
    int first;
    @(posedge clk); #2;
    rst_n = 1'b0;
    mode  = pins[1:0];
    hi    = h[0];
    #1;
    chk(!lrck && !bclk, "R7 clocks low in reset", {lrck, bclk}, 0);
    chk(slave && speed == 2'b11, "R7 idle mode in reset", {slave, speed}, 7);
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 1200 && first == 0; k++) begin
      @(posedge clk); #2;
      if (lrck) first = k;
    end
    if (per > 0)
      chk(first == per / 2 + 1, "R8 first frame rise", first, per / 2 + 1);
  endtask

  // One frame measured at 2 ns after every master-clock transition.
  task automatic measure(output int per, output int nb, output int bad);
    logic pl, pb;
    int   hs;
    bit   started;
    per = 0; nb = 0; bad = 0; hs = 0; started = 0;
    @(clk); #2;
    pl = lrck; pb = bclk;
    for (int i = 0; i < 4000; i++) begin
      @(clk); #2;
      if (lrck != pl && !(pb && !bclk)) bad++;
      if (started) begin
        hs++;
        if (!pb && bclk) nb++;
      end
      if (!pl && lrck) begin
        if (started) begin
          per = hs / 2;
          break;
        end
        started = 1;
      end
      pl = lrck; pb = bclk;
    end
  endtask

  initial begin
    int per, nb, bad, hits;
    rst_n = 1'b0; mode = 2'b00; hi = 1'b0;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      do_reset(V_PINS[v], V_HI[v], V_PER[v]);
      chk(speed == V_SPD[v][1:0], "R1/R2 speed code", speed, V_SPD[v]);
      chk(slave == V_SLV[v][0], "R1/R2 slave flag", slave, V_SLV[v]);
      if (V_SLV[v] == 0) begin
        measure(per, nb, bad);
        chk(per == V_PER[v], "R3 frame period", per, V_PER[v]);
        chk(nb == 64, "R4 bits per frame", nb, 64);
        chk(bad == 0, "R6 frame edge on bit fall", bad, 0);
      end else begin
        hits = 0;
        for (int i = 0; i < 1200; i++) begin
          @(clk); #2;
          if (lrck || bclk) hits++;
        end
        chk(hits == 0, "R2 slave clocks low", hits, 0);
      end
    end

    // R9: strap changes while running are ignored
    do_reset(0, 0, 256);
    mode = 2'b10; hi = 1'b1;
    repeat (20) @(posedge clk);
    #2;
    chk(speed == 2'b00 && !slave, "R9 speed held", speed, 0);
    measure(per, nb, bad);
    chk(per == 256, "R9 period held", per, 256);
    mode = 2'b11;
    measure(per, nb, bad);
    chk(per == 256 && !slave, "R9 slave strap ignored", per, 256);

    // R5: pass-through bit clock at quad speed low ratio
    do_reset(2, 0, 64);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      @(clk); #2;
      if (bclk != ~clk) hits++;
    end
    chk(hits == 0, "R5 bit clock follows inverted master clock", hits, 0);

    // R8 again at double speed, doubled ratio
    do_reset(1, 1, 256);
    chk(speed == 2'b01, "R8 double speed after reset", speed, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule